// File: doc/BRIEF.md
# Two-Operand Addressing Mode Unit

This unit sits at the front of a small 16-bit minicomputer-style core and handles operand addressing for two-operand instructions. When started, it takes a snapshot of the eight general registers. Register 7 acts as the program counter. The unit then reads the instruction word from memory and decodes the source and destination operand fields in that order. For each operand it computes the effective address and applies the mode's side effect to the register file. This includes reading an index word when the mode needs one. ALU work, branching and interrupts belong to other blocks.

Each operand field is six bits: a 3-bit mode code above a 3-bit register number. The mode codes are register (0), post-increment (2), pre-decrement (4) and indexed (6). When register 7 is used with post-increment, the operand is an immediate literal stored in the word after the opcode. When register 7 is used with indexed mode, the operand is PC-relative. Memory is byte-addressed and read as aligned 16-bit words. A read request is answered with data one cycle later. At the end of the instruction the unit raises `done` for one cycle. While `done` is high it presents the opcode, both effective addresses, the mode flags and the updated register values.

Top module: `addr_mode_unit`

## Requirements
- R1: While reset is applied and until the first `start`, `done` and `mem_req` stay low.
- R2: After `start`, the instruction word is read at the address held in register 7, and register 7 then advances by 2. `opcode` reports bits 15..12 of that word, the source field is bits 11..6 and the destination field is bits 5..0.
- R3: Mode code 0 (register mode) sets the operand's `*_is_reg` flag. It reports an effective address of 0, changes no register and reads no extra word.
- R4: Mode code 2 (post-increment) reports the register's current value as the effective address, then adds 2 to that register.
- R5: Mode code 2 with register 7 yields an immediate operand. The effective address is the word following the words already consumed, and register 7 moves past that word by 2.
- R6: Mode code 4 (pre-decrement) subtracts 2 from the register first, then reports the new value as the effective address.
- R7: Mode code 6 (indexed) reads an index word at the address in register 7 and advances register 7 by 2. The effective address is the index word plus the register's value, with modulo 2^16 wrap.
- R8: Mode code 6 with register 7 adds the index word to the address just past that index word. For example, an index of -54 read at 1202 gives 1150.
- R9: The source operand is processed completely, including its index word and its side effect, before the destination. The destination therefore sees register values and a program counter already updated by the source.
- R10: Mode codes 1, 3, 5 and 7 set `illegal_mode`, report an effective address of 0 and change no register.
- R11: An odd effective address from mode 2, 4 or 6 sets `misaligned`. All flags are cleared at `start`.
- R12: `done` is high for exactly one cycle per instruction, and `mem_req` is low while `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin one instruction and load `regs_in` |
| regs_in | input | 128 | Register snapshot, register i at bits [16i+15:16i] |
| mem_req | output | 1 | Memory word read request |
| mem_addr | output | 16 | Byte address of the requested word |
| mem_rdata | input | 16 | Read data, valid the cycle after the request |
| done | output | 1 | One-cycle completion pulse |
| opcode | output | 4 | Decoded operation field |
| src_ea | output | 16 | Source effective address |
| dst_ea | output | 16 | Destination effective address |
| src_is_reg | output | 1 | Source uses register mode |
| dst_is_reg | output | 1 | Destination uses register mode |
| illegal_mode | output | 1 | An operand carried an undefined mode code |
| misaligned | output | 1 | An effective address was odd |
| regs_out | output | 128 | Register values after all side effects |

## Verification
The stimulus pairs mode combinations so that each one separates a different pair of behaviours. Register-register instructions isolate the fetch step. Post-increment against pre-decrement on separate registers shows whether the update comes before or after the address is taken. The same register used with both modes in one instruction exposes any lost or reordered side effect. Two index words in one instruction, and two immediates in one instruction, show that the source's words are consumed first and that the PC-relative base is the post-index address. The example with an index of -54 pins that base exactly. Undefined mode codes and an odd base register confirm that the error flags appear without disturbing the registers.

// File: rtl/amu_pkg.sv
package amu_pkg;
  localparam int unsigned DATA_W  = 16;
  localparam int unsigned NUM_REG = 8;
  localparam int unsigned IDX_W   = $clog2(NUM_REG);
  localparam int unsigned PC_IDX  = NUM_REG - 1;
  localparam int unsigned STEP    = 2;

  typedef enum logic [2:0] {
    AM_REG  = 3'd0,
    AM_AINC = 3'd2,
    AM_ADEC = 3'd4,
    AM_IDX  = 3'd6
  } am_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_IRWAIT,
    ST_OPND,
    ST_XWAIT,
    ST_DONE
  } am_state_e;
endpackage

// File: rtl/amu_operand_calc.sv
module amu_operand_calc
  import amu_pkg::*;
#(
  parameter int unsigned DW = DATA_W
) (
  input  logic [2:0]    mode,
  input  logic [DW-1:0] rval,
  input  logic [DW-1:0] xword,
  input  logic          x_phase,
  output logic [DW-1:0] ea,
  output logic [DW-1:0] rnew,
  output logic          wr_en,
  output logic          needs_x,
  output logic          is_reg,
  output logic          illegal
);
  localparam logic [DW-1:0] STEP_V = DW'(STEP);

  always_comb begin
    ea      = '0;
    rnew    = rval;
    wr_en   = 1'b0;
    needs_x = 1'b0;
    is_reg  = 1'b0;
    illegal = 1'b0;
    case (mode)
      AM_REG:  is_reg = 1'b1;
      AM_AINC: begin
        ea    = rval;
        rnew  = rval + STEP_V;
        wr_en = 1'b1;
      end
      AM_ADEC: begin
        rnew  = rval - STEP_V;
        ea    = rval - STEP_V;
        wr_en = 1'b1;
      end
      AM_IDX: begin
        needs_x = !x_phase;
        ea      = xword + rval;
      end
      default: illegal = 1'b1;
    endcase
  end

  always_comb begin
    if (illegal) begin
      AST_ILLEGAL_NO_EFFECT: assert (!wr_en && !needs_x && !is_reg); // R10
    end
  end
endmodule

// File: rtl/amu_regfile.sv
module amu_regfile
  import amu_pkg::*;
#(
  parameter int unsigned DW   = DATA_W,
  parameter int unsigned NREG = NUM_REG,
  localparam int unsigned IW  = $clog2(NREG),
  localparam int unsigned FW  = DW * NREG
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [FW-1:0] load_flat,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic [IW-1:0] rd_idx,
  output logic [DW-1:0] rd_data,
  output logic [DW-1:0] pc_out,
  output logic [FW-1:0] regs_flat
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [DW-1:0] q;
    logic          we;
    logic [DW-1:0] d;

    always_comb begin
      we = load || (wr_en && (wr_idx == IW'(g)));
      d  = load ? load_flat[g*DW +: DW] : wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else if (we) q <= d;
    end

    assign regs_flat[g*DW +: DW] = q;
  end

  assign rd_data = regs_flat[rd_idx*DW +: DW];
  assign pc_out  = regs_flat[(NREG-1)*DW +: DW];

  AST_LOAD_NOT_WITH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !(load && wr_en)); // R9
endmodule

// File: rtl/addr_mode_unit.sv
module addr_mode_unit
  import amu_pkg::*;
#(
  parameter int unsigned DW   = DATA_W,
  parameter int unsigned NREG = NUM_REG,
  localparam int unsigned IW  = $clog2(NREG),
  localparam int unsigned FW  = DW * NREG,
  localparam int unsigned PCI = NREG - 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [FW-1:0] regs_in,
  output logic          mem_req,
  output logic [DW-1:0] mem_addr,
  input  logic [DW-1:0] mem_rdata,
  output logic          done,
  output logic [3:0]    opcode,
  output logic [DW-1:0] src_ea,
  output logic [DW-1:0] dst_ea,
  output logic          src_is_reg,
  output logic          dst_is_reg,
  output logic          illegal_mode,
  output logic          misaligned,
  output logic [FW-1:0] regs_out
);
  localparam logic [DW-1:0] STEP_V = DW'(STEP);

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_sync;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ni = rst_sync[1];

  am_state_e     state_q, state_d;
  logic          sel_q, sel_d;
  logic [DW-1:0] ir_q, ir_d;
  logic [DW-1:0] sea_q, sea_d, dea_q, dea_d;
  logic          sreg_q, sreg_d, dreg_q, dreg_d;
  logic          ill_q, ill_d, mis_q, mis_d;

  logic          rf_load, rf_wr;
  logic [IW-1:0] rf_widx;
  logic [DW-1:0] rf_wdata, rf_rdata, pc;

  logic [5:0]    fld;
  logic [2:0]    f_mode;
  logic [IW-1:0] f_reg;
  logic [DW-1:0] c_ea, c_rnew;
  logic          c_wr, c_needx, c_isreg, c_ill;

  assign fld    = sel_q ? ir_q[5:0] : ir_q[11:6];
  assign f_mode = fld[5:3];
  assign f_reg  = IW'(fld[2:0]);

  amu_regfile #(.DW(DW), .NREG(NREG)) u_rf (
    .clk       (clk),
    .rst_n     (rst_ni),
    .load      (rf_load),
    .load_flat (regs_in),
    .wr_en     (rf_wr),
    .wr_idx    (rf_widx),
    .wr_data   (rf_wdata),
    .rd_idx    (f_reg),
    .rd_data   (rf_rdata),
    .pc_out    (pc),
    .regs_flat (regs_out)
  );

  amu_operand_calc #(.DW(DW)) u_calc (
    .mode    (f_mode),
    .rval    (rf_rdata),
    .xword   (mem_rdata),
    .x_phase (state_q == ST_XWAIT),
    .ea      (c_ea),
    .rnew    (c_rnew),
    .wr_en   (c_wr),
    .needs_x (c_needx),
    .is_reg  (c_isreg),
    .illegal (c_ill)
  );

  // next-state logic
  always_comb begin
    state_d  = state_q;
    sel_d    = sel_q;
    ir_d     = ir_q;
    sea_d    = sea_q;
    dea_d    = dea_q;
    sreg_d   = sreg_q;
    dreg_d   = dreg_q;
    ill_d    = ill_q;
    mis_d    = mis_q;
    mem_req  = 1'b0;
    mem_addr = pc;
    rf_load  = 1'b0;
    rf_wr    = 1'b0;
    rf_widx  = IW'(PCI);
    rf_wdata = pc + STEP_V;

    case (state_q)
      ST_IDLE: begin
        if (start) begin
          rf_load = 1'b1;
          sea_d   = '0;
          dea_d   = '0;
          sreg_d  = 1'b0;
          dreg_d  = 1'b0;
          ill_d   = 1'b0;
          mis_d   = 1'b0;
          state_d = ST_FETCH;
        end
      end
      ST_FETCH: begin
        mem_req = 1'b1;
        rf_wr   = 1'b1;
        state_d = ST_IRWAIT;
      end
      ST_IRWAIT: begin
        ir_d    = mem_rdata;
        sel_d   = 1'b0;
        state_d = ST_OPND;
      end
      ST_OPND, ST_XWAIT: begin
        if (c_needx) begin
          mem_req = 1'b1;
          rf_wr   = 1'b1;
          state_d = ST_XWAIT;
        end else begin
          rf_wr    = c_wr;
          rf_widx  = f_reg;
          rf_wdata = c_rnew;
          if (sel_q) begin
            dea_d  = c_ea;
            dreg_d = c_isreg;
          end else begin
            sea_d  = c_ea;
            sreg_d = c_isreg;
          end
          ill_d   = ill_q | c_ill;
          mis_d   = mis_q | (!c_isreg && !c_ill && c_ea[0]);
          sel_d   = 1'b1;
          state_d = sel_q ? ST_DONE : ST_OPND;
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sel_q   <= 1'b0;
      ir_q    <= '0;
      sea_q   <= '0;
      dea_q   <= '0;
      sreg_q  <= 1'b0;
      dreg_q  <= 1'b0;
      ill_q   <= 1'b0;
      mis_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      sel_q   <= sel_d;
      ir_q    <= ir_d;
      sea_q   <= sea_d;
      dea_q   <= dea_d;
      sreg_q  <= sreg_d;
      dreg_q  <= dreg_d;
      ill_q   <= ill_d;
      mis_q   <= mis_d;
    end
  end

  assign done         = (state_q == ST_DONE);
  assign opcode       = ir_q[15:12];
  assign src_ea       = sea_q;
  assign dst_ea       = dea_q;
  assign src_is_reg   = sreg_q;
  assign dst_is_reg   = dreg_q;
  assign illegal_mode = ill_q;
  assign misaligned   = mis_q;

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_ni)
    done |=> !done); // R12
  AST_DONE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_ni)
    done |-> !mem_req); // R12
  AST_FETCH_STEPS_PC: assert property (@(posedge clk) disable iff (!rst_ni)
    mem_req |=> (pc == $past(mem_addr) + STEP_V)); // R2
  AST_XWAIT_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == ST_XWAIT) |-> $past(mem_req)); // R7
  AST_ILLEGAL_REGS_HELD: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == ST_OPND && c_ill) |=> $stable(regs_out)); // R10
  AST_SRC_BEFORE_DST: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == ST_DONE) |-> $past(sel_q)); // R9
endmodule

// File: tb/sim_addr_mode_unit.sv
`timescale 1ns/1ps
module sim_addr_mode_unit;
  typedef struct packed {
    logic [3:0]   op;
    logic [15:0]  sea;
    logic [15:0]  dea;
    logic         sreg;
    logic         dreg;
    logic         ill;
    logic         mis;
    logic [127:0] regs;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [127:0] regs_in = '0;
  logic         mem_req;
  logic [15:0]  mem_addr;
  logic [15:0]  mem_rdata = '0;
  logic         done;
  logic [3:0]   opcode;
  logic [15:0]  src_ea, dst_ea;
  logic         src_is_reg, dst_is_reg, illegal_mode, misaligned;
  logic [127:0] regs_out;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;
  bit chk_gap = 0;

  logic [15:0] mem [1024];
  logic [15:0] m_reg [8];
  exp_t  exp_q [$];
  string tag_q [$];

  always #2 clk = ~clk;

  addr_mode_unit u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .regs_in(regs_in),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .done(done), .opcode(opcode), .src_ea(src_ea), .dst_ea(dst_ea),
    .src_is_reg(src_is_reg), .dst_is_reg(dst_is_reg),
    .illegal_mode(illegal_mode), .misaligned(misaligned), .regs_out(regs_out)
  );

  // memory model: one-cycle read latency
  always @(posedge clk) if (mem_req) mem_rdata <= mem[mem_addr[10:1]];

  task automatic chk(string tag, string what, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] enc(int op, int sm, int sr, int dm, int dr);
    return {op[3:0], sm[2:0], sr[2:0], dm[2:0], dr[2:0]};
  endfunction

  // reference model written from the requirements
  task automatic build_exp(output exp_t e);
    logic [15:0] r [8];
    logic [15:0] ir, x, ea;
    logic [5:0]  fld;
    for (int i = 0; i < 8; i++) r[i] = m_reg[i];
    e = '0;
    ir = mem[r[7][10:1]];
    r[7] = r[7] + 16'd2;
    e.op = ir[15:12];
    for (int f = 0; f < 2; f++) begin
      fld = (f == 0) ? ir[11:6] : ir[5:0];
      ea = 16'd0;
      case (fld[5:3])
        3'd0: if (f == 0) e.sreg = 1'b1; else e.dreg = 1'b1;
        3'd2: begin ea = r[fld[2:0]]; r[fld[2:0]] = r[fld[2:0]] + 16'd2; e.mis |= ea[0]; end
        3'd4: begin r[fld[2:0]] = r[fld[2:0]] - 16'd2; ea = r[fld[2:0]]; e.mis |= ea[0]; end
        3'd6: begin
          x = mem[r[7][10:1]];
          r[7] = r[7] + 16'd2;
          ea = x + r[fld[2:0]];
          e.mis |= ea[0];
        end
        default: e.ill = 1'b1;
      endcase
      if (f == 0) e.sea = ea; else e.dea = ea;
    end
    for (int i = 0; i < 8; i++) e.regs[i*16 +: 16] = r[i];
  endtask

  // driver
  task automatic run_case(string tag);
    exp_t e;
    build_exp(e);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    for (int i = 0; i < 8; i++) regs_in[i*16 +: 16] = m_reg[i];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (chk_gap) begin
      chk("R12", "done pulse width", {127'd0, done}, 128'd0);
      chk_gap = 0;
    end
    if (done && exp_q.size() != 0) begin
      exp_t  e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(t, "opcode R2", {124'd0, opcode}, {124'd0, e.op});
      chk(t, "src_ea", {112'd0, src_ea}, {112'd0, e.sea});
      chk(t, "dst_ea", {112'd0, dst_ea}, {112'd0, e.dea});
      chk(t, "src_is_reg", {127'd0, src_is_reg}, {127'd0, e.sreg});
      chk(t, "dst_is_reg", {127'd0, dst_is_reg}, {127'd0, e.dreg});
      chk(t, "illegal_mode", {127'd0, illegal_mode}, {127'd0, e.ill});
      chk(t, "misaligned", {127'd0, misaligned}, {127'd0, e.mis});
      chk(t, "regs_out", regs_out, e.regs);
      chk("R12", "mem_req at done", {127'd0, mem_req}, 128'd0);
      chk_gap = 1;
    end
  end

  task automatic clear_regs();
    for (int i = 0; i < 8; i++) m_reg[i] = 16'h0000;
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 16'h0000;
    clear_regs();
    repeat (3) @(negedge clk);
    chk("R1", "done in reset", {127'd0, done}, 128'd0);
    chk("R1", "mem_req in reset", {127'd0, mem_req}, 128'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "done idle", {127'd0, done}, 128'd0);
    chk("R1", "mem_req idle", {127'd0, mem_req}, 128'd0);

    // R3: register to register
    clear_regs(); m_reg[7] = 16'h0100; m_reg[2] = 16'h1234; m_reg[3] = 16'h0055;
    mem[16'h0100 >> 1] = enc(1, 0, 2, 0, 3);
    run_case("R3 R2");

    // R4 R6: post-increment source, pre-decrement destination
    clear_regs(); m_reg[7] = 16'h0120; m_reg[2] = 16'h0200; m_reg[6] = 16'h0400;
    mem[16'h0120 >> 1] = enc(2, 2, 2, 4, 6);
    run_case("R4 R6");

    // R5: immediate source
    clear_regs(); m_reg[7] = 16'h0140; m_reg[3] = 16'h0009;
    mem[16'h0140 >> 1] = enc(3, 2, 7, 0, 3);
    mem[16'h0142 >> 1] = 16'h00AA;
    run_case("R5");

    // R7 R8 R9: indexed source then PC-relative destination
    clear_regs(); m_reg[7] = 16'h0160; m_reg[1] = 16'h0300;
    mem[16'h0160 >> 1] = enc(4, 6, 1, 6, 7);
    mem[16'h0162 >> 1] = 16'h0010;
    mem[16'h0164 >> 1] = 16'hFFF0;
    run_case("R7 R8 R9");

    // R8: relative source, index -54 read at 1202 gives 1150
    clear_regs(); m_reg[7] = 16'd1200; m_reg[0] = 16'd317;
    mem[1200 >> 1] = enc(1, 6, 7, 0, 0);
    mem[1202 >> 1] = 16'hFFCA;
    run_case("R8");

    // R9: same register post-incremented then pre-decremented
    clear_regs(); m_reg[7] = 16'h0180; m_reg[1] = 16'h0220;
    mem[16'h0180 >> 1] = enc(5, 2, 1, 4, 1);
    run_case("R9");

    // R10: undefined mode codes
    clear_regs(); m_reg[7] = 16'h01A0; m_reg[2] = 16'h0202; m_reg[3] = 16'h0304;
    mem[16'h01A0 >> 1] = enc(6, 1, 2, 5, 3);
    run_case("R10");
    clear_regs(); m_reg[7] = 16'h01A4; m_reg[4] = 16'h0100;
    mem[16'h01A4 >> 1] = enc(6, 3, 4, 7, 4);
    run_case("R10");

    // R11: odd base register
    clear_regs(); m_reg[7] = 16'h01C0; m_reg[4] = 16'h0301;
    mem[16'h01C0 >> 1] = enc(7, 2, 4, 0, 0);
    run_case("R11");

    // R11: flags cleared at next start
    clear_regs(); m_reg[7] = 16'h01C4; m_reg[5] = 16'h0040;
    mem[16'h01C4 >> 1] = enc(7, 4, 5, 0, 1);
    run_case("R11");

    // R5 R9: immediate in both operands
    clear_regs(); m_reg[7] = 16'h01E0;
    mem[16'h01E0 >> 1] = enc(8, 2, 7, 2, 7);
    run_case("R5 R9");

    // R7: indexed with negative index and wrap
    clear_regs(); m_reg[7] = 16'h0200; m_reg[5] = 16'h0004; m_reg[6] = 16'h0010;
    mem[16'h0200 >> 1] = enc(9, 6, 5, 4, 6);
    mem[16'h0202 >> 1] = 16'hFFF8;
    run_case("R7 R6");

    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule